// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog

This block is a watchdog that software must service inside a time window rather than merely before a deadline. Time is measured only in pulses of an external idle-timer tick input. A counter restarts at every service and at every fault. A service that arrives before the fixed lower limit of 256 ticks is a fault, because it points to a tight loop that still contains the service write. Letting the count reach the programmable upper limit is also a fault, and so is a write that carries the wrong key pattern. Each fault produces a reset request pulse lasting one cycle.

Software services the block by writing one byte. The byte carries a key that must match, a two-bit field that picks the upper limit, and an enable bit for a clock monitor. The limit field and the enable bit are taken from the first accepted service after reset and then stay fixed until the next reset. When the clock monitor is enabled, it counts edge strobes from a monitored clock between pulses of a reference tick. It raises an error pulse when too few strobes arrived, which shows that the monitored clock is missing or running too slowly.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset, rst_req and clk_err are 0, the tick count is 0, the upper limit is 2048 ticks and the clock monitor is disabled.
- R2: A write whose key field, in bits 5:1, differs from binary 01100 raises rst_req for one cycle, in the cycle after the write, and restarts the count at 0.
- R3: A write with the correct key while the count is below 256 raises rst_req in the cycle after the write and restarts the count.
- R4: A write with the correct key while the count is 256 or more is accepted. It restarts the count and raises no rst_req.
- R5: If no write occurs, the tick that brings the count up to the upper limit raises rst_req in the next cycle and restarts the count at 0.
- R6: Bits 7:6 of an accepted write select an upper limit of 2048 shifted left by their value: 0 gives 2048, 1 gives 4096, 2 gives 8192 and 3 gives 16384.
- R7: Only the first accepted write after reset sets the limit select and the monitor enable (bit 0). Later writes leave both unchanged until rst_n is asserted.
- R8: When a write and a tick fall in the same cycle, the write is judged against the count before that tick, and the tick is discarded.
- R9: While the monitor is enabled, each ref_tick closes an interval. If fewer than 2 mon_edge pulses arrived in that interval, counting one in the same cycle as ref_tick, clk_err is 1 in the next cycle for one cycle.
- R10: While the monitor is disabled, clk_err stays 0 whatever the mon_edge rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Idle-timer tick strobe, one cycle per tick |
| svc_we | input | 1 | Write strobe for the service byte |
| svc_data | input | 8 | Service byte: limit select, key, monitor enable |
| mon_edge | input | 1 | Strobe, one per edge of the monitored clock |
| ref_tick | input | 1 | Reference tick that closes each monitor interval |
| rst_req | output | 1 | One-cycle reset request on a watchdog fault |
| clk_err | output | 1 | One-cycle slow or missing clock error |

## Verification
A service write and an idle-timer tick can fall in the same cycle. The case that matters is the cycle in which that tick would reach the upper limit. The bench runs the count up to one tick below the 4096 limit and then drives the tick and a valid write together. It expects the write to be accepted with no reset request, and the behavioural model and a directed check both judge that outcome. The bench also drives a mon_edge strobe in the same cycle as ref_tick, and expects that strobe to count toward the interval being closed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int SEL_W = 2;
    localparam int KEY_W = 5;
    localparam logic [KEY_W-1:0] SVC_KEY = 5'b01100;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [KEY_W-1:0] key;
        logic             mon_en;
    } svc_byte_t;

    typedef struct packed {
        logic             locked;
        logic [SEL_W-1:0] sel;
        logic             mon_en;
    } wdg_cfg_t;
endpackage

// File: rtl/wdg_svc_decode.sv
module wdg_svc_decode
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       svc_data,
    input  logic             accept,
    output logic             key_ok,
    output logic [SEL_W-1:0] sel,
    output logic             mon_en
);
    svc_byte_t fields;
    wdg_cfg_t  cfg_d, cfg_q;

    always_comb begin
        fields = svc_byte_t'(svc_data);
        key_ok = (fields.key == SVC_KEY);
        cfg_d  = cfg_q;
        if (accept && !cfg_q.locked) begin
            cfg_d.locked = 1'b1;
            cfg_d.sel    = fields.sel;
            cfg_d.mon_en = fields.mon_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel    = cfg_q.sel;
    assign mon_en = cfg_q.mon_en;

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.locked |=> ($stable(cfg_q.sel) && $stable(cfg_q.mon_en) && cfg_q.locked));
endmodule

// File: rtl/wdg_window_ctr.sv
module wdg_window_ctr
    import wdg_pkg::*;
#(
    parameter int BASE_UPPER = 2048,
    parameter int LOWER      = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             svc_we,
    input  logic             key_ok,
    input  logic [SEL_W-1:0] sel,
    output logic             accept,
    output logic             rst_req
);
    localparam int CNT_W = $clog2(BASE_UPPER) + (1 << SEL_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } win_state_t;

    win_state_t       st_d, st_q;
    logic [CNT_W-1:0] upper;
    logic             early;

    always_comb begin
        upper  = CNT_W'(BASE_UPPER) << sel;
        early  = (st_q.cnt < CNT_W'(LOWER));
        accept = svc_we && key_ok && !early;
        st_d   = st_q;
        st_d.req = 1'b0;
        if (svc_we) begin
            st_d.cnt = '0;
            st_d.req = !accept;
        end else if (tick) begin
            if (st_q.cnt + CNT_W'(1) == upper) begin
                st_d.cnt = '0;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.req;

    p_badkey_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_we && !key_ok) |=> (rst_req && st_q.cnt == '0));
    p_early_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_we && st_q.cnt < CNT_W'(LOWER)) |=> rst_req);
    p_accept_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!rst_req && st_q.cnt == '0));
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < upper);
endmodule

// File: rtl/wdg_clk_mon.sv
module wdg_clk_mon #(
    parameter int MIN_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mon_edge,
    input  logic ref_tick,
    output logic clk_err
);
    localparam int MON_W = $clog2(MIN_EDGES + 1);

    typedef struct packed {
        logic [MON_W-1:0] edges;
        logic             err;
    } mon_state_t;

    mon_state_t       st_d, st_q;
    logic [MON_W-1:0] total;

    always_comb begin
        if (mon_edge && st_q.edges != MON_W'(MIN_EDGES))
            total = st_q.edges + MON_W'(1);
        else
            total = st_q.edges;
        st_d     = st_q;
        st_d.err = 1'b0;
        if (ref_tick) begin
            st_d.err   = enable && (total < MON_W'(MIN_EDGES));
            st_d.edges = '0;
        end else begin
            st_d.edges = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_err = st_q.err;

    p_err_on_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err |-> $past(ref_tick));
    p_err_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err |-> $past(enable));
endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
    import wdg_pkg::*;
#(
    parameter int BASE_UPPER = 2048,
    parameter int LOWER      = 256,
    parameter int MIN_EDGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    input  logic       mon_edge,
    input  logic       ref_tick,
    output logic       rst_req,
    output logic       clk_err
);
    logic             key_ok;
    logic             accept;
    logic [SEL_W-1:0] sel;
    logic             mon_en;

    wdg_svc_decode i_decode (
        .clk(clk), .rst_n(rst_n), .svc_data(svc_data), .accept(accept),
        .key_ok(key_ok), .sel(sel), .mon_en(mon_en)
    );

    wdg_window_ctr #(.BASE_UPPER(BASE_UPPER), .LOWER(LOWER)) i_window (
        .clk(clk), .rst_n(rst_n), .tick(tick), .svc_we(svc_we),
        .key_ok(key_ok), .sel(sel), .accept(accept), .rst_req(rst_req)
    );

    wdg_clk_mon #(.MIN_EDGES(MIN_EDGES)) i_mon (
        .clk(clk), .rst_n(rst_n), .enable(mon_en), .mon_edge(mon_edge),
        .ref_tick(ref_tick), .clk_err(clk_err)
    );

    p_no_req_without_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_we && !tick) |=> !rst_req);
endmodule

// File: tb/test_windowed_watchdog.sv
module test_windowed_watchdog;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       mon_edge = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rst_req, clk_err;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_cycles = 0;
    string cur_req = "R1";

    int m_cnt = 0, m_sel = 0, m_cm = 0, m_lock = 0, m_edges = 0;
    int exp_rst = 0, exp_err = 0;

    windowed_watchdog i_windowed_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .svc_we(svc_we),
        .svc_data(svc_data), .mon_edge(mon_edge), .ref_tick(ref_tick),
        .rst_req(rst_req), .clk_err(clk_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sel = 0; m_cm = 0; m_lock = 0; m_edges = 0;
            exp_rst = 0; exp_err = 0;
        end else begin
            int total;
            exp_rst = 0;
            exp_err = 0;
            total = m_edges + (mon_edge ? 1 : 0);
            if (ref_tick) begin
                exp_err = (m_cm != 0 && total < 2) ? 1 : 0;
                m_edges = 0;
            end else begin
                m_edges = (total > 2) ? 2 : total;
            end
            if (svc_we) begin
                if (((svc_data >> 1) & 31) != 12 || m_cnt < 256) exp_rst = 1;
                else if (m_lock == 0) begin
                    m_lock = 1; m_sel = svc_data[7:6]; m_cm = svc_data[0];
                end
                m_cnt = 0;
            end else if (tick) begin
                if (m_cnt + 1 == (2048 << m_sel)) begin
                    exp_rst = 1; m_cnt = 0;
                end else m_cnt++;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        n_cycles++;
        if (rst_n) begin
            check(cur_req, "rst_req model", rst_req, exp_rst);
            check(cur_req, "clk_err model", clk_err, exp_err);
        end
        if (n_cycles > 150000) begin
            check("watchdog", "timeout", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic step(logic t, logic we, logic [7:0] d, logic me, logic rt);
        @(negedge clk);
        tick = t; svc_we = we; svc_data = d; mon_edge = me; ref_tick = rt;
    endtask

    task automatic run_ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic expect_out(string tag, logic er, logic ee);
        @(posedge clk); #1;
        check(tag, "rst_req", rst_req, er);
        check(tag, "clk_err", clk_err, ee);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 0; svc_we = 0; svc_data = 0; mon_edge = 0; ref_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        cur_req = "R1";
        step(0, 0, 8'h00, 0, 0);
        expect_out("R1", 0, 0);

        // R5: expiry at default limit 2048
        cur_req = "R5";
        run_ticks(2047);
        expect_out("R5", 0, 0);
        step(1, 0, 8'h00, 0, 0);
        expect_out("R5", 1, 0);
        step(0, 0, 8'h00, 0, 0);
        expect_out("R5", 0, 0);

        // R3: valid key too early
        cur_req = "R3";
        run_ticks(10);
        step(0, 1, 8'h59, 0, 0);
        expect_out("R3", 1, 0);

        // R4: valid service inside window, sel=1 mon_en=1
        cur_req = "R4";
        run_ticks(300);
        step(0, 1, 8'h59, 0, 0);
        expect_out("R4", 0, 0);

        // R6: limit now 4096
        cur_req = "R6";
        run_ticks(4095);
        expect_out("R6", 0, 0);
        step(1, 0, 8'h00, 0, 0);
        expect_out("R6", 1, 0);

        // R7: later service with sel=0 mon_en=0 is accepted but does not reconfigure
        cur_req = "R7";
        run_ticks(300);
        step(0, 1, 8'h18, 0, 0);
        expect_out("R7", 0, 0);
        run_ticks(2048);
        expect_out("R7", 0, 0);
        run_ticks(2047);
        step(1, 0, 8'h00, 0, 0);
        expect_out("R7", 1, 0);

        // R8: write and tick in the cycle that would reach the limit
        cur_req = "R8";
        run_ticks(4095);
        step(1, 1, 8'h18, 0, 0);
        expect_out("R8", 0, 0);
        step(1, 0, 8'h00, 0, 0);
        expect_out("R8", 0, 0);

        // R2: wrong key inside window
        cur_req = "R2";
        run_ticks(300);
        step(0, 1, 8'h5B, 0, 0);
        expect_out("R2", 1, 0);
        step(0, 0, 8'h00, 0, 0);
        expect_out("R2", 0, 0);

        // R9: monitor enabled (locked from R4)
        cur_req = "R9";
        step(0, 0, 8'h00, 0, 1);
        step(0, 0, 8'h00, 1, 0);
        step(0, 0, 8'h00, 1, 0);
        step(0, 0, 8'h00, 1, 1);
        expect_out("R9", 0, 0);
        step(0, 0, 8'h00, 0, 0);
        step(0, 0, 8'h00, 1, 1);
        expect_out("R9", 0, 1);
        step(0, 0, 8'h00, 1, 0);
        step(0, 0, 8'h00, 0, 1);
        expect_out("R9", 0, 1);
        step(0, 0, 8'h00, 1, 0);
        step(0, 0, 8'h00, 0, 0);
        step(0, 0, 8'h00, 1, 1);
        expect_out("R9", 0, 0);

        // R10: monitor disabled after a fresh reset and a cm=0 first service
        do_reset();
        cur_req = "R10";
        run_ticks(300);
        step(0, 1, 8'h18, 0, 0);
        expect_out("R10", 0, 0);
        step(0, 0, 8'h00, 0, 1);
        expect_out("R10", 0, 0);
        step(0, 0, 8'h00, 1, 1);
        expect_out("R10", 0, 0);
        step(0, 0, 8'h00, 0, 0);
        step(0, 0, 8'h00, 0, 1);
        expect_out("R10", 0, 0);

        // R1: reset clears the lock, so the default 2048 limit applies again
        do_reset();
        cur_req = "R1";
        run_ticks(2047);
        step(1, 0, 8'h00, 0, 0);
        expect_out("R1", 1, 0);
        step(0, 0, 8'h00, 0, 0);
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule